// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, naturally aligned regions of a 32-bit effective address space straight onto physical regions, without walking any page table. It keeps two small banks of register pairs, one consulted for instruction fetches and one for every other access. Each pair has an upper word and a lower word. The upper word holds the effective region, its length mask and two validity bits, one for supervisor mode and one for user mode. The lower word holds the physical region base and a two-bit protection code.

A lookup request carries an effective address, an access kind and a user/supervisor flag. The unit answers with exactly one outcome. A hit returns a translated address. A violation means the deciding entry denies the access. A miss means no entry applies. Requests enter through a valid/ready handshake and results leave through another one. A request is taken on any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no result is held or the held result is being consumed in that cycle. While `rsp_ready` stays low, a held result keeps every field unchanged.

The register banks are loaded through a plain write port, one 32-bit word per cycle. A write that lands in the same cycle as an accepted request does not affect that request.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset every entry of both banks reads as zero, so no entry is valid. `rsp_valid` is 0, `req_ready` is 1, and any lookup returns a miss.
- R2: A request accepted at a clock edge produces its result with `rsp_valid` high one cycle later. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, the result fields stay unchanged and no new request is taken.
- R3: Whenever `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_viol` and `rsp_miss` is 1.
- R4: An entry covers an address when EA[31:28] equals upper[31:28] and EA[27:17], with the bits selected by the length field upper[12:2] forced to 0, equals upper[27:17]. Upper bit k of the length field masks EA bit k+15.
- R5: A covering entry applies only if upper[1] is set for a supervisor access (`req_user`=0), or upper[0] is set for a user access (`req_user`=1).
- R6: On a hit, PA[31:28] = lower[31:28]. PA[27:17] = lower[27:17] OR (EA[27:17] AND length mask). PA[16:0] = EA[16:0].
- R7: The protection code lower[1:0] decodes as follows. 00 denies every access. 10 grants load, store and fetch. 01 and 11 grant load and fetch but deny store. Kind codes: 0 load, 1 store, 2 fetch, 3 treated as load.
- R8: The lowest-index applicable entry alone decides the outcome. If it denies the access, the result is a violation even when a higher-index applicable entry would grant it.
- R9: Kind 2 (fetch) consults the instruction bank. All other kinds consult the data bank.
- R10: On a miss or a violation, `rsp_pa` is zero.
- R11: When `wr_en` is high, `wr_data` is written to bank `wr_set` (1 = instruction, 0 = data), entry `wr_idx`, into the upper word if `wr_hi`=1 and the lower word otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can take a request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Access granted and translated |
| rsp_viol | output | 1 | Deciding entry denies the access |
| rsp_miss | output | 1 | No applicable entry |
| rsp_pa | output | 32 | Physical address on hit, else zero |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | 2 | Entry index |
| wr_hi | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to write |

## Verification
On every cycle, the assertions check the handshake rules: ready follows the held state, and a stalled result does not move. They also check that each result has a single outcome, that a non-hit carries a zero address, and that a hit passes the low seventeen address bits through. Whether the right entry decided, whether the length mask kept or dropped the right bits, and whether the privilege bit and protection code were honoured depend on the programmed register contents. Only the directed scenarios can show those. They cover a fixed-size block, a fully masked block, a partly masked instruction block, priority against a denying entry, and privilege-based skipping.

// File: rtl/bat_pkg.sv
package bat_pkg;

  localparam int unsigned ADDR_W = 32;

  localparam logic [ADDR_W-1:0] REGION_TOP_MSK = 32'hF000_0000;
  localparam logic [ADDR_W-1:0] REGION_MID_MSK = 32'h0FFE_0000;
  localparam logic [ADDR_W-1:0] PASS_LOW_MSK   = 32'h0001_FFFF;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  // Expand the 11-bit length field (upper[12:2]) to a mask over EA[27:17].
  function automatic logic [ADDR_W-1:0] len_mask(input logic [ADDR_W-1:0] upper);
    return {4'h0, upper[12:2], 17'h0};
  endfunction

  // Protection decode: 00 none, 10 all, x1 read/execute only.
  function automatic logic prot_allows(input logic [1:0] code, input acc_kind_e kind);
    logic rd_ok, wr_ok;
    rd_ok = (code != 2'b00);
    wr_ok = (code == 2'b10);
    case (kind)
      ACC_STORE: return wr_ok;
      default:   return rd_ok;
    endcase
  endfunction

endpackage

// File: rtl/bat_bank_regs.sv
module bat_bank_regs
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                wr_set,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic                                wr_hi,
  input  logic [ADDR_W-1:0]                   wr_data,
  input  logic                                rd_instr,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  rd_upper,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  rd_lower
);

  logic [1:0][NUM_ENTRIES-1:0][ADDR_W-1:0] upper_q;
  logic [1:0][NUM_ENTRIES-1:0][ADDR_W-1:0] lower_q;

  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic sel_w;
      assign sel_w = wr_en && (wr_set == s[0]) && (wr_idx == e[IDX_W-1:0]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          upper_q[s][e] <= '0;
          lower_q[s][e] <= '0;
        end else if (sel_w) begin
          if (wr_hi) upper_q[s][e] <= wr_data;
          else       lower_q[s][e] <= wr_data;
        end
      end
    end
  end

  assign rd_upper = rd_instr ? upper_q[1] : upper_q[0];
  assign rd_lower = rd_instr ? lower_q[1] : lower_q[0];

endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [ADDR_W-1:0] ea,
  input  acc_kind_e         kind,
  input  logic              user,
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] lower,
  output logic              applies,
  output logic              allow,
  output logic [ADDR_W-1:0] pa
);

  logic [ADDR_W-1:0] blen;
  logic              top_eq;
  logic              mid_eq;
  logic              priv_ok;
  logic              unused_fields;

  assign blen    = len_mask(upper);
  assign top_eq  = (ea & REGION_TOP_MSK) == (upper & REGION_TOP_MSK);
  assign mid_eq  = ((ea & REGION_MID_MSK) & ~blen) == (upper & REGION_MID_MSK);
  assign priv_ok = user ? upper[0] : upper[1];
  assign applies = top_eq && mid_eq && priv_ok;
  assign allow   = prot_allows(lower[1:0], kind);

  assign pa = (lower & REGION_TOP_MSK)
            | (ea & REGION_MID_MSK & blen)
            | (lower & REGION_MID_MSK)
            | (ea & PASS_LOW_MSK);

  assign unused_fields = ^{upper[16:13], lower[16:2]};

endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
)(
  input  logic [NUM_ENTRIES-1:0]              applies,
  input  logic [NUM_ENTRIES-1:0]              allow,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  pa_in,
  output logic                                hit,
  output logic                                viol,
  output logic                                miss,
  output logic [ADDR_W-1:0]                   pa
);

  logic              found;
  logic              granted;
  logic [ADDR_W-1:0] pa_pick;

  // Scan from the top so the lowest applicable index is the last to write.
  always_comb begin
    found   = 1'b0;
    granted = 1'b0;
    pa_pick = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (applies[i]) begin
        found   = 1'b1;
        granted = allow[i];
        pa_pick = pa_in[i];
      end
    end
  end

  assign hit  = found && granted;
  assign viol = found && !granted;
  assign miss = !found;
  assign pa   = hit ? pa_pick : '0;

endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_ea,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_viol,
  output logic              rsp_miss,
  output logic [31:0]       rsp_pa,
  input  logic              wr_en,
  input  logic              wr_set,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data
);

  acc_kind_e                         kind;
  logic                              use_instr;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] bank_upper;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] bank_lower;
  logic [NUM_ENTRIES-1:0]            ent_applies;
  logic [NUM_ENTRIES-1:0]            ent_allow;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_pa;
  logic                              c_hit, c_viol, c_miss;
  logic [ADDR_W-1:0]                 c_pa;
  logic                              accept;

  assign kind      = acc_kind_e'(req_kind);
  assign use_instr = (kind == ACC_FETCH);

  bat_bank_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_idx   (wr_idx),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .rd_instr (use_instr),
    .rd_upper (bank_upper),
    .rd_lower (bank_lower)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    bat_entry_match u_match (
      .ea      (req_ea),
      .kind    (kind),
      .user    (req_user),
      .upper   (bank_upper[e]),
      .lower   (bank_lower[e]),
      .applies (ent_applies[e]),
      .allow   (ent_allow[e]),
      .pa      (ent_pa[e])
    );
  end

  bat_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .applies (ent_applies),
    .allow   (ent_allow),
    .pa_in   (ent_pa),
    .hit     (c_hit),
    .viol    (c_viol),
    .miss    (c_miss),
    .pa      (c_pa)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_viol  <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= c_hit;
      rsp_viol  <= c_viol;
      rsp_miss  <= c_miss;
      rsp_pa    <= c_pa;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_ea,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic        rsp_viol,
  input logic        rsp_miss,
  input logic [31:0] rsp_pa
);

  logic [31:0] ea_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      ea_q <= '0;
    else if (req_valid && req_ready) ea_q <= req_ea;
  end

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                   && $stable(rsp_viol) && $stable(rsp_miss))); // R2

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_viol, rsp_miss}) == 1)); // R3

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_pa[16:0] == ea_q[16:0])); // R6

  AST_PA_ZERO_NONHIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == 32'h0)); // R10

endmodule

bind bat_xlate_unit bat_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ea    (req_ea),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_viol  (rsp_viol),
  .rsp_miss  (rsp_miss),
  .rsp_pa    (rsp_pa)
);

// File: tb/sim_bat_xlate_unit.sv
`timescale 1ns/1ps
module sim_bat_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_viol, rsp_miss;
  logic [31:0] rsp_pa;
  logic        wr_en = 1'b0;
  logic        wr_set = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic        wr_hi = 1'b0;
  logic [31:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_IF = 2'd2;
  localparam logic [2:0] O_HIT = 3'b100, O_VIOL = 3'b010, O_MISS = 3'b001;

  always #2 clk = ~clk;

  bat_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_viol(rsp_viol), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
    .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input bit set, input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = set; wr_idx = idx[1:0]; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [1:0] kind, input bit user,
                        input logic [2:0] exp_o, input logic [31:0] exp_pa, input string tag);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, {tag, " rsp_valid"}, {34'h0, rsp_valid}, 35'h1);
    check({rsp_hit, rsp_viol, rsp_miss, rsp_pa} === {exp_o, exp_pa}, tag,
          {rsp_hit, rsp_viol, rsp_miss, rsp_pa}, {exp_o, exp_pa});
  endtask

  // R1: reset state and empty banks
  task automatic t_reset;
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", {34'h0, rsp_valid}, 35'h0);
    check(req_ready === 1'b1, "R1 req_ready after reset", {34'h0, req_ready}, 35'h1);
    lookup(32'h8001_5ABC, K_LD, 1'b0, O_MISS, 32'h0, "R1 empty data bank miss");
    lookup(32'h8001_5ABC, K_IF, 1'b0, O_MISS, 32'h0, "R1 empty instr bank miss");
  endtask

  // R11 R6 R5 R4: fixed 128 KiB supervisor block in data entry 0
  task automatic t_small_block;
    write_word(1'b0, 0, 1'b1, 32'h8000_0002);
    write_word(1'b0, 0, 1'b0, 32'h1234_0002);
    lookup(32'h8001_5ABC, K_LD, 1'b0, O_HIT, 32'h1235_5ABC, "R6 small block load");
    lookup(32'h8001_5ABC, K_ST, 1'b0, O_HIT, 32'h1235_5ABC, "R7 small block store rw");
    lookup(32'h8001_5ABC, K_LD, 1'b1, O_MISS, 32'h0, "R5 user skips supervisor-only");
    lookup(32'h8002_0000, K_LD, 1'b0, O_MISS, 32'h0, "R4 just past block");
    lookup(32'h8001_5ABC, K_IF, 1'b0, O_MISS, 32'h0, "R9 fetch uses instr bank");
  endtask

  // R4 R7 R8 R10: full-mask block read/exec in entry 1, rw copy in entry 2
  task automatic t_large_block;
    write_word(1'b0, 1, 1'b1, 32'hA000_1FFF);
    write_word(1'b0, 1, 1'b0, 32'h4000_0001);
    lookup(32'hA765_4321, K_LD, 1'b1, O_HIT, 32'h4765_4321, "R4 full mask user load");
    lookup(32'hA765_4321, K_ST, 1'b1, O_VIOL, 32'h0, "R7 code 01 denies store");
    write_word(1'b0, 2, 1'b1, 32'hA000_1FFF);
    write_word(1'b0, 2, 1'b0, 32'h5000_0002);
    lookup(32'hA765_4321, K_ST, 1'b0, O_VIOL, 32'h0, "R8 lowest entry denies");
    write_word(1'b0, 2, 1'b1, 32'hB000_0002);
    write_word(1'b0, 2, 1'b0, 32'h0000_0000);
    lookup(32'hB000_0010, K_LD, 1'b0, O_VIOL, 32'h0, "R7 code 00 denies load");
  endtask

  // R5 R8: user-only entry 3 after supervisor-only entry 0 on same region
  task automatic t_priv_skip;
    write_word(1'b0, 3, 1'b1, 32'h8000_0001);
    write_word(1'b0, 3, 1'b0, 32'h6000_0002);
    lookup(32'h8001_5ABC, K_LD, 1'b1, O_HIT, 32'h6001_5ABC, "R8 skip to user entry");
    lookup(32'h8001_5ABC, K_LD, 1'b0, O_HIT, 32'h1235_5ABC, "R5 supervisor keeps entry 0");
  endtask

  // R9 R4 R6: partly masked instruction block (mask over EA[18:17])
  task automatic t_instr_partial;
    write_word(1'b1, 0, 1'b1, 32'h9060_000E);
    write_word(1'b1, 0, 1'b0, 32'h3080_0001);
    lookup(32'h9066_B123, K_IF, 1'b0, O_HIT, 32'h3086_B123, "R6 partial mask fetch");
    lookup(32'h9068_0000, K_IF, 1'b0, O_MISS, 32'h0, "R4 unmasked bit differs");
    lookup(32'h9066_B123, K_LD, 1'b0, O_MISS, 32'h0, "R9 load ignores instr bank");
  endtask

  // R2: back-pressure holds the result, next request waits
  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h8001_5ABC; req_kind = K_LD; req_user = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b1 && req_ready === 1'b0, "R2 stalled ready low",
          {33'h0, rsp_valid, req_ready}, 35'h2);
    req_ea = 32'hA765_4321; req_user = 1'b1;
    @(negedge clk);
    check({rsp_hit, rsp_viol, rsp_miss, rsp_pa} === {O_HIT, 32'h1235_5ABC}, "R2 held result",
          {rsp_hit, rsp_viol, rsp_miss, rsp_pa}, {O_HIT, 32'h1235_5ABC});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && {rsp_hit, rsp_viol, rsp_miss, rsp_pa} === {O_HIT, 32'h4765_4321},
          "R2 waiting request taken", {rsp_hit, rsp_viol, rsp_miss, rsp_pa}, {O_HIT, 32'h4765_4321});
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2 drained", {34'h0, rsp_valid}, 35'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_block();
    t_large_block();
    t_priv_skip();
    t_instr_partial();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule